// File: doc/BRIEF.md
# Write-Coalescing Command Packer

This block turns a stream of register write requests into a packed instruction buffer for a downstream write executor. Each request carries a register offset, a data value and a flag that selects direct or indexed mode. A direct request becomes a two-word instruction. Indexed requests to the same register, one after another, are folded into one instruction whose leading count word is rewritten in place each time another value is appended. All buffer traffic leaves through a single word-wide write port, at one word per clock.

A flush closes the buffer. It zero-fills up to the next 64-byte boundary and reports the tail as a byte count. It then rewinds the free pointer and the instruction-start pointer to zero. A request that arrives once the free pointer has reached the configured capacity is dropped, and an overflow pulse is raised.

Top module: `wcp_packer`

## Requirements
- R1: After reset, req_ready is high, and mem_we, overflow and flush_done are low.
- R2: An accepted direct request (req_indexed=0) writes two words at the free pointer F. The first is the value, at F. The second, at F+1, is a command word with 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0. The instruction start becomes F, and F advances by 2.
- R3: An indexed request that does not merge first rounds F up to an even word address E. It then writes three words: the count 1 at E, a command word at E+1 with 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0, and the value at E+2. The instruction start becomes E.
- R4: An indexed request whose offset equals bits 19:0 of the word after the instruction start merges. It writes its value at F, advances F by 1, and rewrites the word at the instruction start with that word plus one. This holds even when the open instruction is a direct one, whose command word carries the matching offset.
- R5: When an indexed request leaves F odd, one extra zero word is written at F, and F does not advance.
- R6: After reset or after a flush, the first indexed request always opens a new instruction, whatever its offset.
- R7: A request accepted while F is at least DEPTH writes nothing and leaves the buffer unchanged. overflow is high for exactly the cycle that follows acceptance.
- R8: A flush with F nonzero writes zeros from F up to the next multiple of 16 words (64 bytes). It then pulses flush_done for one cycle, with flush_tail equal to that boundary in bytes, and both pointers return to zero.
- R9: A flush with F equal to zero writes nothing, raises no flush_done, and leaves the block ready.
- R10: When flush_req is high in an idle cycle, req_ready is low in that cycle and the flush is taken before any pending request. flush_req in a busy cycle is ignored.
- R11: Each accepted request writes exactly its words, one per cycle: 2 for direct, 3 for a new indexed instruction or 2 for a merge, plus 1 for padding, and 0 when dropped. req_ready stays low until the last word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_indexed | input | 1 | 1 selects indexed mode, 0 selects direct mode |
| req_offset | input | OFF_W | Register offset |
| req_value | input | 32 | Register value |
| flush_req | input | 1 | Close the buffer (honoured only when idle) |
| flush_done | output | 1 | One-cycle pulse when a flush completes |
| flush_tail | output | AW+2 | Tail in bytes, valid with flush_done |
| overflow | output | 1 | One-cycle pulse after a dropped request |
| mem_we | output | 1 | Buffer word write strobe |
| mem_addr | output | AW | Buffer word address |
| mem_wdata | output | 32 | Buffer word data |

## Verification
A flush request and a write request can both be presented in the same idle cycle. The bench provokes this by raising flush_req and req_valid together on one edge. It checks that req_ready drops at once, that the flush completes with the tail of the old contents, and that the held request then lands at word zero of the rewound buffer. That last point is confirmed by the buffer image at the next flush. Overflow is also checked when it coincides with the end of a multi-word instruction: a buffer with a small capacity is filled by random traffic until requests are dropped.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
  localparam int WORD_W    = 32;
  localparam int FILL_LOG2 = 4;  // 16 words = 64 bytes
  localparam int PAIR_LOG2 = 1;  // 8-byte instruction alignment
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL     = 4'hF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DVAL,
    S_DCMD,
    S_ICNT,
    S_ICMD,
    S_IVAL,
    S_PATCH,
    S_PAD,
    S_FILL,
    S_DONE
  } wcp_state_e;
endpackage

// File: rtl/wcp_word_fmt.sv
module wcp_word_fmt #(
  parameter int OFF_W = 20
) (
  input  logic                       indexed,
  input  logic [OFF_W-1:0]           offset,
  output logic [wcp_pkg::WORD_W-1:0] cmd
);
  logic [19:0] off_ext;

  assign off_ext = 20'(offset);
  assign cmd = indexed ? {wcp_pkg::OP_INDEXED, 4'h0, off_ext}
                       : {wcp_pkg::OP_DIRECT, wcp_pkg::BE_ALL, off_ext};
endmodule

// File: rtl/wcp_align.sv
module wcp_align #(
  parameter int W    = 8,
  parameter int LOG2 = 1
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] up
);
  localparam logic [W-1:0] MASK = W'((1 << LOG2) - 1);

  assign up = (val + MASK) & ~MASK;
endmodule

// File: rtl/wcp_seq.sv
module wcp_seq
  import wcp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFF_W = 20,
  parameter int AW    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_indexed,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [WORD_W-1:0] req_value,
  input  logic              flush_req,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [AW-1:0]     free_even,
  input  logic [AW-1:0]     free_tail,
  output logic [AW-1:0]     free_ptr,
  output logic [OFF_W-1:0]  lat_offset,
  output logic              lat_indexed,
  output logic              flush_done,
  output logic [AW+1:0]     flush_tail,
  output logic              overflow,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam logic [AW-1:0] CAP = AW'(DEPTH);

  wcp_state_e        st_q, st_d;
  logic [AW-1:0]     free_q, free_d;
  logic [AW-1:0]     start_q, start_d;
  logic [AW-1:0]     tail_q, tail_d;
  logic [OFF_W-1:0]  cur_off_q, cur_off_d;
  logic              cur_vld_q, cur_vld_d;
  logic [WORD_W-1:0] head_q, head_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [WORD_W-1:0] val_q, val_d;
  logic              idx_q, idx_d;
  logic              merge_q, merge_d;
  logic              ovf_q, ovf_d;
  logic              idle;

  assign idle        = (st_q == S_IDLE);
  assign req_ready   = idle && !flush_req;
  assign free_ptr    = free_q;
  assign lat_offset  = off_q;
  assign lat_indexed = idx_q;
  assign overflow    = ovf_q;
  assign flush_done  = (st_q == S_DONE);
  assign flush_tail  = {tail_q, 2'b00};

  always_comb begin
    st_d      = st_q;
    free_d    = free_q;
    start_d   = start_q;
    tail_d    = tail_q;
    cur_off_d = cur_off_q;
    cur_vld_d = cur_vld_q;
    head_d    = head_q;
    off_d     = off_q;
    val_d     = val_q;
    idx_d     = idx_q;
    merge_d   = merge_q;
    ovf_d     = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = free_q;
    mem_wdata = '0;
    case (st_q)
      S_IDLE: begin
        if (flush_req) begin
          if (free_q != '0) begin
            tail_d = free_tail;
            st_d   = S_FILL;
          end
        end else if (req_valid) begin
          if (free_q >= CAP) begin
            ovf_d = 1'b1;
          end else begin
            off_d = req_offset;
            val_d = req_value;
            idx_d = req_indexed;
            if (!req_indexed) begin
              start_d = free_q;
              st_d    = S_DVAL;
            end else if (cur_vld_q && (cur_off_q == req_offset)) begin
              merge_d = 1'b1;
              st_d    = S_IVAL;
            end else begin
              merge_d = 1'b0;
              free_d  = free_even;
              start_d = free_even;
              st_d    = S_ICNT;
            end
          end
        end
      end
      S_DVAL: begin
        mem_we    = 1'b1;
        mem_wdata = val_q;
        free_d    = free_q + 1'b1;
        st_d      = S_DCMD;
      end
      S_DCMD: begin
        mem_we    = 1'b1;
        mem_wdata = cmd_word;
        free_d    = free_q + 1'b1;
        cur_off_d = off_q;
        cur_vld_d = 1'b1;
        head_d    = val_q;
        st_d      = S_IDLE;
      end
      S_ICNT: begin
        mem_we    = 1'b1;
        mem_wdata = WORD_W'(1);
        free_d    = free_q + 1'b1;
        st_d      = S_ICMD;
      end
      S_ICMD: begin
        mem_we    = 1'b1;
        mem_wdata = cmd_word;
        free_d    = free_q + 1'b1;
        st_d      = S_IVAL;
      end
      S_IVAL: begin
        mem_we    = 1'b1;
        mem_wdata = val_q;
        free_d    = free_q + 1'b1;
        if (merge_q) begin
          st_d = S_PATCH;
        end else begin
          cur_off_d = off_q;
          cur_vld_d = 1'b1;
          head_d    = WORD_W'(1);
          st_d      = free_q[0] ? S_IDLE : S_PAD;
        end
      end
      S_PATCH: begin
        mem_we    = 1'b1;
        mem_addr  = start_q;
        mem_wdata = head_q + 1'b1;
        head_d    = head_q + 1'b1;
        st_d      = free_q[0] ? S_PAD : S_IDLE;
      end
      S_PAD: begin
        mem_we = 1'b1;
        st_d   = S_IDLE;
      end
      S_FILL: begin
        if (free_q == tail_q) begin
          st_d = S_DONE;
        end else begin
          mem_we = 1'b1;
          free_d = free_q + 1'b1;
        end
      end
      S_DONE: begin
        free_d    = '0;
        start_d   = '0;
        cur_vld_d = 1'b0;
        st_d      = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      free_q    <= '0;
      start_q   <= '0;
      tail_q    <= '0;
      cur_off_q <= '0;
      cur_vld_q <= 1'b0;
      head_q    <= '0;
      off_q     <= '0;
      val_q     <= '0;
      idx_q     <= 1'b0;
      merge_q   <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      free_q    <= free_d;
      start_q   <= start_d;
      tail_q    <= tail_d;
      cur_off_q <= cur_off_d;
      cur_vld_q <= cur_vld_d;
      head_q    <= head_d;
      off_q     <= off_d;
      val_q     <= val_d;
      idx_q     <= idx_d;
      merge_q   <= merge_d;
      ovf_q     <= ovf_d;
    end
  end

  p_write_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready);
  p_count_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ICNT) |-> (mem_addr[0] == 1'b0));
  p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (!mem_we && idle));
  p_tail_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> ((flush_tail[5:0] == 6'd0) && (flush_tail != '0)));
  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> (free_q == '0));
  p_patch_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PATCH) |-> (mem_addr < free_q));
endmodule

// File: rtl/wcp_packer.sv
module wcp_packer #(
  parameter int DEPTH = 256,
  parameter int OFF_W = 20,
  localparam int AW   = $clog2(DEPTH) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_indexed,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [31:0]      req_value,
  input  logic             flush_req,
  output logic             flush_done,
  output logic [AW+1:0]    flush_tail,
  output logic             overflow,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata
);
  logic [31:0]      cmd_word;
  logic [AW-1:0]    free_ptr;
  logic [AW-1:0]    free_even;
  logic [AW-1:0]    free_tail;
  logic [OFF_W-1:0] lat_offset;
  logic             lat_indexed;

  wcp_word_fmt #(.OFF_W(OFF_W)) u_fmt (
    .indexed (lat_indexed),
    .offset  (lat_offset),
    .cmd     (cmd_word)
  );

  wcp_align #(.W(AW), .LOG2(wcp_pkg::PAIR_LOG2)) u_pair (
    .val (free_ptr),
    .up  (free_even)
  );

  wcp_align #(.W(AW), .LOG2(wcp_pkg::FILL_LOG2)) u_line (
    .val (free_ptr),
    .up  (free_tail)
  );

  wcp_seq #(.DEPTH(DEPTH), .OFF_W(OFF_W), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_indexed (req_indexed),
    .req_offset  (req_offset),
    .req_value   (req_value),
    .flush_req   (flush_req),
    .cmd_word    (cmd_word),
    .free_even   (free_even),
    .free_tail   (free_tail),
    .free_ptr    (free_ptr),
    .lat_offset  (lat_offset),
    .lat_indexed (lat_indexed),
    .flush_done  (flush_done),
    .flush_tail  (flush_tail),
    .overflow    (overflow),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );
endmodule

// File: tb/tb_wcp_packer.sv
module tb_wcp_packer;
  localparam int DEPTH = 32;
  localparam int OFF_W = 20;
  localparam int AW    = $clog2(DEPTH) + 2;
  localparam int MEMW  = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_indexed;
  logic [OFF_W-1:0] req_offset;
  logic [31:0]      req_value;
  logic             flush_req;
  logic             flush_done;
  logic [AW+1:0]    flush_tail;
  logic             overflow;
  logic             mem_we;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_wdata;

  wcp_packer #(.DEPTH(DEPTH), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_offset(req_offset), .req_value(req_value),
    .flush_req(flush_req), .flush_done(flush_done), .flush_tail(flush_tail),
    .overflow(overflow), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [31:0] img [MEMW];
  logic [31:0] exp_mem [MEMW];
  int wr_cnt = 0;
  int checks = 0;
  int fails  = 0;
  int e_free = 0;
  int e_start = 0;
  bit e_vld = 0;

  always @(negedge clk) begin
    if (mem_we) begin
      img[mem_addr] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Apply one request to the model; returns words expected and overflow flag.
  task automatic model_req(input bit idx, input logic [19:0] off, input logic [31:0] val,
                           output int words, output bit ovf, output string tag);
    ovf = 0; words = 0; tag = "R7 drop";
    if (e_free >= DEPTH) begin
      ovf = 1;
    end else if (!idx) begin
      e_start = e_free;
      exp_mem[e_free]   = val;
      exp_mem[e_free+1] = {8'h01, 4'hF, off};
      e_free += 2; e_vld = 1; words = 2; tag = "R2 direct";
    end else if (e_vld && exp_mem[e_start+1][19:0] == off) begin
      exp_mem[e_free] = val;
      e_free += 1;
      exp_mem[e_start] = exp_mem[e_start] + 1;
      words = 2; tag = "R4 merge";
      if (e_free % 2 == 1) begin exp_mem[e_free] = 0; words++; tag = "R4/R5 merge+pad"; end
    end else begin
      e_free = (e_free + 1) & ~1;
      e_start = e_free;
      exp_mem[e_free]   = 1;
      exp_mem[e_free+1] = {8'h09, 4'h0, off};
      exp_mem[e_free+2] = val;
      e_free += 3; e_vld = 1; words = 3; tag = "R3 new";
      if (e_free % 2 == 1) begin exp_mem[e_free] = 0; words++; tag = "R3/R5 new+pad"; end
    end
  endtask

  task automatic send(input bit idx, input logic [19:0] off, input logic [31:0] val,
                      input string extra);
    int words; bit ovf; string tag; int w0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model_req(idx, off, val, words, ovf, tag);
    w0 = wr_cnt;
    req_valid = 1; req_indexed = idx; req_offset = off; req_value = val;
    @(negedge clk);
    req_valid = 0;
    chk(overflow == ovf, {"R7 overflow pulse ", extra}, overflow, ovf);
    while (!req_ready) @(negedge clk);
    chk((wr_cnt - w0) == words, {"R11 word count ", tag, " ", extra}, wr_cnt - w0, words);
  endtask

  task automatic model_flush_and_check(input string tag);
    int tail; bit seen; int bad;
    tail = (e_free + 15) & ~15;
    for (int i = e_free; i < tail; i++) exp_mem[i] = 0;
    seen = 0;
    for (int c = 0; c < 100 && !seen; c++) begin
      @(negedge clk);
      if (flush_done) seen = 1;
    end
    chk(seen, {"R8 flush_done ", tag}, seen, 1);
    chk(flush_tail == tail * 4, {"R8 tail bytes ", tag}, flush_tail, tail * 4);
    bad = -1;
    for (int i = 0; i < tail; i++) if (bad < 0 && img[i] !== exp_mem[i]) bad = i;
    if (bad >= 0) chk(0, $sformatf("R2/R3/R4/R5/R8 image word %0d %s", bad, tag), img[bad], exp_mem[bad]);
    else chk(1, "image", 0, 0);
    e_free = 0; e_start = 0; e_vld = 0;
  endtask

  task automatic do_flush(input string tag);
    int w0; bit seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    w0 = wr_cnt;
    flush_req = 1;
    #1;
    chk(!req_ready, {"R10 ready low on flush ", tag}, req_ready, 0);
    @(negedge clk);
    flush_req = 0;
    if (e_free == 0) begin
      seen = 0;
      for (int c = 0; c < 20; c++) begin
        if (flush_done) seen = 1;
        @(negedge clk);
      end
      chk(!seen && wr_cnt == w0 && req_ready, {"R9 empty flush ", tag}, wr_cnt - w0, 0);
    end else begin
      model_flush_and_check(tag);
    end
  endtask

  task automatic flush_with_req(input bit idx, input logic [19:0] off, input logic [31:0] val);
    int words; bit ovf; string tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flush_req = 1; req_valid = 1; req_indexed = idx; req_offset = off; req_value = val;
    #1;
    chk(!req_ready, "R10 flush wins the cycle", req_ready, 0);
    @(negedge clk);
    flush_req = 0;
    model_flush_and_check("R10 concurrent");
    while (!req_ready) @(negedge clk);
    model_req(idx, off, val, words, ovf, tag);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] offs [4];
    void'($urandom(32'd4242));
    offs[0] = 20'h00040; offs[1] = 20'h00040; offs[2] = 20'hFFFF0; offs[3] = 20'h12340;
    for (int i = 0; i < MEMW; i++) begin img[i] = 32'hDEAD_BEEF; exp_mem[i] = 32'hDEAD_BEEF; end
    rst_n = 0; req_valid = 0; req_indexed = 0; req_offset = '0; req_value = '0; flush_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_we && !overflow && !flush_done, "R1 reset state",
        {req_ready, mem_we, overflow, flush_done}, 4'b1000);

    do_flush("R9 after reset");
    send(0, 20'h12345, 32'hA5A5_0001, "R2");
    send(1, 20'h00100, 32'h0000_1111, "R3 even start");
    send(1, 20'h00100, 32'h0000_2222, "R4 no pad");
    send(1, 20'h00100, 32'h0000_3333, "R4 pad");
    send(1, 20'h00200, 32'h0000_4444, "R3 round up");
    do_flush("R8 directed");
    send(1, 20'h00200, 32'h0000_5555, "R6 first after flush");
    send(0, 20'hABCDE, 32'h0000_0010, "R2 second");
    send(1, 20'hABCDE, 32'h0000_6666, "R4 onto direct");
    flush_with_req(1, 20'h00200, 32'h0000_7777);
    for (int k = 0; k < 20; k++) send(0, 20'(k), 32'(k), "R7 fill");
    do_flush("R8 after overflow");

    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 6) do_flush("random");
      else if (r < 28) send(0, offs[$urandom_range(0, 3)], $urandom, "random");
      else send(1, offs[$urandom_range(0, 3)], $urandom, "random");
    end
    do_flush("final");
    do_flush("R9 final empty");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule